// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter with Clear-to-Send Gating

This block turns parallel characters into an asynchronous serial stream on a single output line. A character enters through a valid/ready handshake. The block then drives a low start bit, the data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Every bit is held for a programmable number of clock cycles.

Run-time configuration inputs choose the data length (5 to 8 bits), the parity mode (none, even or odd) and the number of stop bits. An active-low clear-to-send input lets the receiving device hold off transmission. The block samples that input only when it is about to accept a new character, so a character that has already started always finishes. The configuration and the divisor are captured together with the character, so changing them mid-character has no effect.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `txd` is high; with `cts_n` low, `in_ready` is high in that state.
- R2: A character is accepted on a rising edge where `in_valid` and `in_ready` are both high. From that edge `txd` is low for one bit time (the start bit).
- R3: The data bits follow the start bit, least significant first. The count is set by `cfg_len`: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are ignored.
- R4: `cfg_parity` 1 (even) adds one bit after the data so that the data plus that bit hold an even number of ones. 2 (odd) makes the total odd. 0 and 3 add no parity bit.
- R5: The stop bits are high: one when `cfg_stop2` is 0, two when it is 1.
- R6: Every bit lasts exactly `cfg_divisor` clock cycles. A divisor of 0 acts as 1.
- R7: `in_ready` is high only while no character is in progress and `cts_n` is low. While `cts_n` is high, no character is accepted and `txd` stays high.
- R8: `cts_n` has an effect only at acceptance. Raising it during a character neither shortens nor changes that character, but it blocks the next one.
- R9: Data, length, parity mode, stop count and divisor are captured at acceptance. Changes to those inputs during a character have no effect on it.
- R10: After the last stop bit ends, the block is idle on the next cycle (`txd` high, `in_ready` high if `cts_n` is low). A character of F bits with divisor D therefore occupies F*D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_divisor | input | 16 | Clock cycles per bit (0 acts as 1) |
| cfg_len | input | 2 | Data length code: 5 + value bits |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cts_n | input | 1 | Active-low clear-to-send from the receiver |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Block will accept a character this cycle |
| txd | output | 1 | Serial output line, idles high |

## Verification
The bench sweeps all 24 framing combinations at divisors 0, 1 and 3, using two data patterns in each. Every cycle of every frame is compared with a bit sequence the bench builds arithmetically, so a wrong bit order, parity sense, stop count or bit length shows up at the exact cycle where it occurs. Separate runs hold `cts_n` high while a character is offered, to show that nothing starts. Other runs raise `cts_n`, or scramble the data and configuration inputs, after acceptance. A frame that still matches exactly shows that these inputs are sampled only at acceptance, and the ready level at the end shows that the next character is blocked.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Smallest data length; the length code adds to this.
    localparam int MIN_DATA = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE2 = 2'd3
    } par_mode_e;

    function automatic logic par_enabled(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic par_is_odd(input par_mode_e m);
        return (m == PAR_ODD);
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] div_m1_q;
    logic [DIV_W-1:0] cnt_q;

    // Divisor captured with the character; zero behaves as one.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_m1_q <= '0;
        end else if (restart) begin
            div_m1_q <= (divisor == '0) ? '0 : divisor - DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == div_m1_q);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              odd,
    output logic              par
);
    logic [DATA_W-1:0] masked;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] && (IDX_W'(i) <= last_idx);
    end

    assign par = (^masked) ^ odd;
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cts_n,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              par_on,
    input  logic              par_val,
    input  logic              two_stop,
    input  logic              tick,
    output logic              in_ready,
    output logic              accept,
    output logic              busy,
    output logic              txd
);
    tx_state_e         state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic              par_on_q;
    logic              par_q;
    logic              two_stop_q;
    logic              stop_cnt_q;
    logic              txd_q;

    assign in_ready = (state_q == ST_IDLE) && !cts_n;
    assign accept   = in_valid && in_ready;
    assign busy     = (state_q != ST_IDLE);
    assign txd      = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            idx_q      <= '0;
            last_q     <= '0;
            par_on_q   <= 1'b0;
            par_q      <= 1'b0;
            two_stop_q <= 1'b0;
            stop_cnt_q <= 1'b0;
            txd_q      <= 1'b1;
        end else if (accept) begin
            state_q    <= ST_START;
            shreg_q    <= in_data;
            last_q     <= last_idx;
            par_on_q   <= par_on;
            par_q      <= par_val;
            two_stop_q <= two_stop;
            txd_q      <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                ST_START: begin
                    state_q <= ST_DATA;
                    idx_q   <= '0;
                    txd_q   <= shreg_q[0];
                    shreg_q <= shreg_q >> 1;
                end
                ST_DATA: begin
                    if (idx_q == last_q) begin
                        if (par_on_q) begin
                            state_q <= ST_PARITY;
                            txd_q   <= par_q;
                        end else begin
                            state_q    <= ST_STOP;
                            stop_cnt_q <= 1'b0;
                            txd_q      <= 1'b1;
                        end
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        txd_q   <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                    end
                end
                ST_PARITY: begin
                    state_q    <= ST_STOP;
                    stop_cnt_q <= 1'b0;
                    txd_q      <= 1'b1;
                end
                ST_STOP: begin
                    if (two_stop_q && !stop_cnt_q) begin
                        stop_cnt_q <= 1'b1;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                    txd_q <= 1'b1;
                end
                default: begin
                    state_q <= ST_IDLE;
                    txd_q   <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_stop2,
    input  logic              cts_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd
);
    localparam int IDX_W = $clog2(DATA_W);

    par_mode_e        pmode;
    logic [IDX_W-1:0] last_idx;
    logic             par_val;
    logic             tick;
    logic             accept;
    logic             busy;

    assign pmode    = par_mode_e'(cfg_parity);
    assign last_idx = IDX_W'(MIN_DATA - 1) + IDX_W'(cfg_len);

    uart_tx_parity #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_par (
        .data     (in_data),
        .last_idx (last_idx),
        .odd      (par_is_odd(pmode)),
        .par      (par_val)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (busy),
        .divisor (cfg_divisor),
        .tick    (tick)
    );

    uart_tx_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cts_n    (cts_n),
        .last_idx (last_idx),
        .par_on   (par_enabled(pmode)),
        .par_val  (par_val),
        .two_stop (cfg_stop2),
        .tick     (tick),
        .in_ready (in_ready),
        .accept   (accept),
        .busy     (busy),
        .txd      (txd)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic cts_n,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy,
    input logic tick,
    input logic accept
);
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!txd && busy));

    p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(accept)) |-> $stable(txd));

    p_cts_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        cts_n |-> !in_ready);

    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cts_n    (cts_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd),
    .busy     (busy),
    .tick     (tick),
    .accept   (accept)
);

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_divisor = 16'd1;
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_parity = 2'd0;
    logic        cfg_stop2 = 1'b0;
    logic        cts_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        txd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk(clk), .rst(rst), .cfg_divisor(cfg_divisor), .cfg_len(cfg_len),
        .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2), .cts_n(cts_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Sends one character and compares every cycle of the frame.
    task automatic send_frame(input logic [7:0] d, input int len, input int par,
                              input int st2, input int div, input int block,
                              input bit mid_cts, input bit scramble);
        int eff, nb, pen, total, pos;
        logic pb;
        logic frame [0:11];
        string seg, extra;
        logic exp_txd, exp_rdy;
        eff = (div == 0) ? 1 : div;
        nb  = 5 + len;
        pen = (par == 1 || par == 2) ? 1 : 0;
        pb  = (par == 2) ? 1'b1 : 1'b0;
        for (int i = 0; i < nb; i++) pb = pb ^ d[i];
        total = 1 + nb + pen + 1 + st2;
        for (int i = 0; i < 12; i++) frame[i] = 1'b1;
        frame[0] = 1'b0;
        for (int i = 0; i < nb; i++) frame[1 + i] = d[i];
        if (pen == 1) frame[1 + nb] = pb;
        extra = (div == 0) ? " R6" : (scramble ? " R9" : (mid_cts ? " R8" : ""));

        @(negedge clk);
        cfg_divisor = 16'(div);
        cfg_len = 2'(len);
        cfg_parity = 2'(par);
        cfg_stop2 = st2[0];
        in_data = d;
        in_valid = 1'b1;
        cts_n = (block > 0);
        for (int k = 0; k < block; k++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R7 ready while cts_n high", int'(in_ready), 0);
            chk(txd == 1'b1, "R7 line idle while cts_n high", int'(txd), 1);
        end
        cts_n = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R7 ready once cts_n low", int'(in_ready), 1);

        for (int n = 0; n <= total * eff; n++) begin
            @(negedge clk);
            pos = n / eff;
            if (n == total * eff) begin
                exp_txd = 1'b1;
                exp_rdy = !cts_n;
                seg = "R10";
            end else begin
                exp_txd = frame[pos];
                exp_rdy = 1'b0;
                if (pos == 0) seg = "R2";
                else if (pos <= nb) seg = "R3";
                else if (pos == nb + 1 && pen == 1) seg = "R4";
                else seg = "R5";
            end
            chk(txd == exp_txd, $sformatf("%s%s txd cyc %0d", seg, extra, n),
                int'(txd), int'(exp_txd));
            chk(in_ready == exp_rdy, $sformatf("%s%s in_ready cyc %0d", seg, extra, n),
                int'(in_ready), int'(exp_rdy));
            if (n == 0) begin
                in_valid = 1'b0;
                if (scramble) begin
                    in_data = ~d;
                    cfg_len = ~cfg_len;
                    cfg_parity = cfg_parity ^ 2'd3;
                    cfg_stop2 = ~cfg_stop2;
                    cfg_divisor = cfg_divisor + 16'd2;
                end
            end
            if (mid_cts && n == eff) cts_n = 1'b1;
        end
        cts_n = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // Full framing sweep at three divisors, two data patterns each.
        for (int len = 0; len < 4; len++)
            for (int par = 0; par < 4; par++)
                for (int st = 0; st < 2; st++)
                    for (int dv = 0; dv < 3; dv++) begin
                        send_frame(8'hA5, len, par, st, (dv == 2) ? 3 : dv, 0, 1'b0, 1'b0);
                        send_frame(8'((len * 53 + par * 29 + st * 101 + dv * 17) ^ 8'h3C),
                                   len, par, st, (dv == 2) ? 3 : dv, 0, 1'b0, 1'b0);
                    end

        // Clear-to-send held off while a character waits.
        send_frame(8'h96, 3, 1, 0, 2, 12, 1'b0, 1'b0);
        send_frame(8'h1F, 0, 2, 1, 1, 5, 1'b0, 1'b0);
        // Clear-to-send raised mid-character: frame completes, next is blocked.
        send_frame(8'hC3, 3, 2, 1, 3, 0, 1'b1, 1'b0);
        send_frame(8'h0D, 1, 0, 0, 4, 0, 1'b1, 1'b0);
        // Inputs scrambled after acceptance.
        send_frame(8'h6E, 2, 1, 0, 3, 0, 1'b0, 1'b1);
        send_frame(8'hF0, 3, 0, 1, 2, 0, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule